// File: doc/BRIEF.md
# Superframe CRC-12 Monitor with Far-End Block Error Reporting

This block protects a framed serial link with a 12-bit cyclic check computed once per superframe. On the transmit side it accumulates the CRC over the bits the framer marks as protected. At each superframe boundary it hands the finished value to the framer, which places it into the reserved check-bit slots of the next superframe. On the receive side it runs the same accumulation over the incoming protected bits. It keeps the result of the superframe that has just closed, and at the following boundary it compares that result with the check bits carried in the superframe after it.

Each comparison gives a near-end verdict. That verdict is presented as the far-end block error flag, which the framer transmits during the next superframe. The block also keeps an 8-bit block error counter that the host can read. The counter starts at all ones and steps down by one for each evaluated superframe that had a local mismatch or that carried a received far-end error bit of zero. The framer qualifies every bit with a valid strobe and with class flags for protected data, check bits and the far-end error bit. A start marker on the first bit of a superframe defines the boundary.

Top module: `sf_crc_mon`

## Requirements
- R1: The transmit CRC uses the generator x^12+x^11+x^3+x^2+x+1 (taps 0x80F). The register is cleared at the first bit of each superframe, and bits enter most significant bit first, in line order. Only bits with `tx_prot_i`=1 take part.
- R2: At every transmit boundary after the first one, `tx_crc_o` takes the CRC of the superframe that has just ended, and `tx_crc_vld_o` is high for that one cycle. Between such pulses `tx_crc_o` does not change.
- R3: Check bits (`rx_chk_i`=1) are shifted in MSB first, and the last 12 received in a superframe form its received CRC. At a receive boundary, that value is compared with the CRC computed over the protected bits of the superframe before it.
- R4: At each evaluation, `febe_o` becomes 1 if the compared values are equal and 0 if they differ. `rx_eval_o` is high for that one cycle, and `febe_o` holds its value until the next evaluation.
- R5: No evaluation takes place at the first two receive boundaries after reset. The first `rx_eval_o` pulse comes at the third boundary.
- R6: `bec_o` decreases by exactly one at an evaluation when there is a mismatch, or when any bit qualified by `rx_febe_i` in the evaluated superframe was 0. At all other times it does not change.
- R7: When a mismatch and a received far-end error bit of 0 occur in the same superframe, the counter decreases only once.
- R8: The counter saturates at 0x00 and never wraps to 0xFF.
- R9: After `rst_ni` low or one cycle of `soft_rst_i`, `bec_o`=0xFF, `febe_o`=1, `tx_crc_o`=0, and neither pulse output is high. The boundary history starts again.
- R10: Cycles with the valid strobe low, and bits with `tx_prot_i`/`rx_prot_i` low, have no effect on either CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset, one cycle |
| tx_vld_i | input | 1 | Transmit bit strobe |
| tx_sf_start_i | input | 1 | Transmit bit is the first of a superframe |
| tx_prot_i | input | 1 | Transmit bit is CRC-protected |
| tx_bit_i | input | 1 | Transmit bit value |
| tx_crc_o | output | 12 | CRC to insert in the next superframe |
| tx_crc_vld_o | output | 1 | One-cycle pulse when tx_crc_o updates |
| rx_vld_i | input | 1 | Receive bit strobe |
| rx_sf_start_i | input | 1 | Receive bit is the first of a superframe |
| rx_prot_i | input | 1 | Receive bit is CRC-protected |
| rx_chk_i | input | 1 | Receive bit is a check bit |
| rx_febe_i | input | 1 | Receive bit is the far-end error bit |
| rx_bit_i | input | 1 | Receive bit value |
| febe_o | output | 1 | Far-end error bit to send, 1 = no error |
| rx_eval_o | output | 1 | One-cycle pulse at each evaluation |
| bec_o | output | 8 | Block error counter |

## Verification
The bench loops a pseudo-random superframe stream into both sides. It predicts every transmit CRC and every evaluation from its own model. Any extra or early pulse underflows its queue, which is how a design that evaluated at the first or second boundary would show up. Superframes are built with a corrupted check field, with a zero far-end bit, and with both at once. A design that charged two errors for the combined case would end one step lower than expected. A long run of errors drives the counter to zero, where a design without saturation would wrap to 0xFF. Idle cycles carrying protected-looking data, check data and zero far-end bits are mixed into one superframe; any leak from them would change the CRC or the counter. A software reset in mid-stream must restore the initial outputs and restart the warm-up.

// File: rtl/sf_crc_pkg.sv
package sf_crc_pkg;
  localparam int unsigned CRC_W    = 12;
  localparam logic [CRC_W-1:0] CRC_POLY = 12'h80F;
  localparam int unsigned BEC_W    = 8;
  localparam int unsigned WARM_N   = 2;
  localparam int unsigned WARM_W   = $clog2(WARM_N + 1);

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [BEC_W-1:0] bec_t;

  function automatic crc_t crc_step(crc_t c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sf_crc_acc.sv
module sf_crc_acc
  import sf_crc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic start_i,
  input  logic prot_i,
  input  logic bit_i,
  output crc_t crc_o
);
  crc_t crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
    end else if (clr_i) begin
      crc_q <= '0;
    end else if (vld_i) begin
      if (start_i) crc_q <= prot_i ? crc_step('0, bit_i) : '0;
      else if (prot_i) crc_q <= crc_step(crc_q, bit_i);
    end
  end

  assign crc_o = crc_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(crc_q)); // R10
endmodule

// File: rtl/sf_chk_cap.sv
module sf_chk_cap
  import sf_crc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic start_i,
  input  logic chk_i,
  input  logic febe_i,
  input  logic bit_i,
  output crc_t sr_o,
  output logic fz_o
);
  crc_t sr_q;
  logic fz_q;
  logic fz_hit;

  assign fz_hit = febe_i & ~bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      fz_q <= 1'b0;
    end else if (clr_i) begin
      sr_q <= '0;
      fz_q <= 1'b0;
    end else if (vld_i) begin
      if (start_i) begin
        sr_q <= chk_i ? crc_t'(bit_i) : '0;
        fz_q <= fz_hit;
      end else begin
        if (chk_i) sr_q <= {sr_q[CRC_W-2:0], bit_i};
        if (fz_hit) fz_q <= 1'b1;
      end
    end
  end

  assign sr_o = sr_q;
  assign fz_o = fz_q;

  AST_FZ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fz_q && !clr_i && !(vld_i && start_i)) |=> fz_q); // R6
endmodule

// File: rtl/sf_bec.sv
module sf_bec
  import sf_crc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic dec_i,
  output bec_t cnt_o
);
  bec_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else if (clr_i) cnt_q <= '1;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !clr_i) |=> cnt_q == '0); // R8
  AST_SOFT_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '1); // R9
endmodule

// File: rtl/sf_crc_mon.sv
module sf_crc_mon
  import sf_crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              tx_vld_i,
  input  logic              tx_sf_start_i,
  input  logic              tx_prot_i,
  input  logic              tx_bit_i,
  output logic [CRC_W-1:0]  tx_crc_o,
  output logic              tx_crc_vld_o,
  input  logic              rx_vld_i,
  input  logic              rx_sf_start_i,
  input  logic              rx_prot_i,
  input  logic              rx_chk_i,
  input  logic              rx_febe_i,
  input  logic              rx_bit_i,
  output logic              febe_o,
  output logic              rx_eval_o,
  output logic [BEC_W-1:0]  bec_o
);
  crc_t tx_acc, rx_acc, chk_sr;
  logic fz;
  logic tx_bnd, rx_bnd, eval_now, mism, dec;

  logic              tx_seen_q, tx_vld_q;
  crc_t              tx_crc_q;
  logic [WARM_W-1:0] warm_q;
  crc_t              prev_q;
  logic              febe_q, eval_q;

  assign tx_bnd = tx_vld_i & tx_sf_start_i;
  assign rx_bnd = rx_vld_i & rx_sf_start_i;

  sf_crc_acc u_tx_acc (
    .clk_i, .rst_ni, .clr_i(soft_rst_i),
    .vld_i(tx_vld_i), .start_i(tx_sf_start_i), .prot_i(tx_prot_i), .bit_i(tx_bit_i),
    .crc_o(tx_acc)
  );

  sf_crc_acc u_rx_acc (
    .clk_i, .rst_ni, .clr_i(soft_rst_i),
    .vld_i(rx_vld_i), .start_i(rx_sf_start_i), .prot_i(rx_prot_i), .bit_i(rx_bit_i),
    .crc_o(rx_acc)
  );

  sf_chk_cap u_cap (
    .clk_i, .rst_ni, .clr_i(soft_rst_i),
    .vld_i(rx_vld_i), .start_i(rx_sf_start_i), .chk_i(rx_chk_i),
    .febe_i(rx_febe_i), .bit_i(rx_bit_i),
    .sr_o(chk_sr), .fz_o(fz)
  );

  // transmit side: publish the finished CRC at each boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_seen_q <= 1'b0;
      tx_vld_q  <= 1'b0;
      tx_crc_q  <= '0;
    end else if (soft_rst_i) begin
      tx_seen_q <= 1'b0;
      tx_vld_q  <= 1'b0;
      tx_crc_q  <= '0;
    end else begin
      tx_vld_q <= tx_bnd & tx_seen_q;
      if (tx_bnd) begin
        tx_seen_q <= 1'b1;
        if (tx_seen_q) tx_crc_q <= tx_acc;
      end
    end
  end

  // receive side: check bits of superframe n cover superframe n-1
  assign eval_now = rx_bnd && (warm_q == WARM_W'(WARM_N));
  assign mism     = (chk_sr != prev_q);
  assign dec      = eval_now & (mism | fz);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      prev_q <= '0;
      febe_q <= 1'b1;
      eval_q <= 1'b0;
    end else if (soft_rst_i) begin
      warm_q <= '0;
      prev_q <= '0;
      febe_q <= 1'b1;
      eval_q <= 1'b0;
    end else begin
      eval_q <= eval_now;
      if (rx_bnd) begin
        prev_q <= rx_acc;
        if (warm_q != WARM_W'(WARM_N)) warm_q <= warm_q + 1'b1;
      end
      if (eval_now) febe_q <= ~mism;
    end
  end

  sf_bec u_bec (
    .clk_i, .rst_ni, .clr_i(soft_rst_i), .dec_i(dec), .cnt_o(bec_o)
  );

  assign tx_crc_o     = tx_crc_q;
  assign tx_crc_vld_o = tx_vld_q;
  assign febe_o       = febe_q;
  assign rx_eval_o    = eval_q;

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_crc_vld_o && !$past(soft_rst_i)) |-> $stable(tx_crc_o)); // R2
  AST_FEBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_eval_o && !$past(soft_rst_i)) |-> $stable(febe_o)); // R4
  AST_BEC_ON_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bec_o != $past(bec_o)) && !$past(soft_rst_i)) |-> rx_eval_o); // R6
  AST_SOFT_OUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (febe_o && !rx_eval_o && !tx_crc_vld_o && tx_crc_o == '0)); // R9
endmodule

// File: tb/sf_crc_mon_test.sv
module sf_crc_mon_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        vld = 1'b0, start = 1'b0, prot = 1'b0, chk = 1'b0, febe_q = 1'b0, b = 1'b0;
  logic [11:0] tx_crc;
  logic        tx_crc_vld, febe, rx_eval;
  logic [7:0]  bec;

  int n_chk = 0, n_bad = 0;

  logic [11:0] q_tx[$];
  string       q_txt[$];
  logic [8:0]  q_rx[$];
  string       q_rxt[$];

  int          k = 0;
  logic [11:0] last_crc = '0;
  logic        last_err = 1'b0, last_fb = 1'b1;
  logic [7:0]  bec_m = 8'hFF;

  always #5 clk = ~clk;

  sf_crc_mon uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .tx_vld_i(vld), .tx_sf_start_i(start), .tx_prot_i(prot), .tx_bit_i(b),
    .tx_crc_o(tx_crc), .tx_crc_vld_o(tx_crc_vld),
    .rx_vld_i(vld), .rx_sf_start_i(start), .rx_prot_i(prot), .rx_chk_i(chk),
    .rx_febe_i(febe_q), .rx_bit_i(b),
    .febe_o(febe), .rx_eval_o(rx_eval), .bec_o(bec)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] crc_mdl(logic [11:0] c, logic d);
    logic f;
    f = c[11] ^ d;
    c = c << 1;
    if (f) c = c ^ 12'b1000_0000_1111;
    return c;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_crc_vld) begin
        if (q_tx.size() == 0) check("R2 R5 unexpected tx pulse", 1, 0);
        else check(q_txt.pop_front(), 32'(tx_crc), 32'(q_tx.pop_front()));
      end
      if (rx_eval) begin
        if (q_rx.size() == 0) check("R5 unexpected evaluation", 1, 0);
        else check(q_rxt.pop_front(), {23'd0, febe, bec}, {23'd0, q_rx.pop_front()});
      end
    end
  end

  task automatic drive(logic v, logic s, logic p, logic c, logic f, logic d);
    @(negedge clk);
    vld = v; start = s; prot = p; chk = c; febe_q = f; b = d;
  endtask

  task automatic send_sf(logic err, logic fb, logic idle);
    logic [11:0] c, chkv;
    logic        d, nebe, dc;
    string       t;
    if (k >= 1) begin
      q_tx.push_back(last_crc);
      q_txt.push_back(idle ? "R1 R2 R10 tx crc" : "R1 R2 tx crc");
    end
    if (k >= 2) begin
      nebe = ~last_err;
      dc   = ~nebe | ~last_fb;
      if (last_err && !last_fb) t = "R7 combined";
      else if (dc && bec_m == 8'h00) t = "R8 floor";
      else if (last_err) t = "R3 R4 R6 mismatch";
      else if (!last_fb) t = "R6 far-end zero";
      else t = "R3 R4 clean";
      if (dc && bec_m != 8'h00) bec_m = bec_m - 8'd1;
      q_rx.push_back({nebe, bec_m});
      q_rxt.push_back(t);
    end
    chkv = last_crc ^ (err ? 12'h5A3 : 12'h000);
    c = '0;
    for (int i = 0; i < 48; i++) begin
      logic p, ck, fq;
      p  = (i < 36) && (i % 4 != 3);
      ck = (i >= 36);
      fq = (i == 3);
      if (ck) d = chkv[11 - (i - 36)];
      else if (fq) d = fb;
      else d = 1'($urandom);
      if (p) c = crc_mdl(c, d);
      drive(1'b1, i == 0, p, ck, fq, d);
      if (idle && (i % 5 == 2)) drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'($urandom) & 1'b0);
      if (idle && (i % 7 == 1)) drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    end
    last_crc = c; last_err = err; last_fb = fb;
    k++;
  endtask

  initial begin
    #(200000 * 10);
    check("watchdog", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset bec", 32'(bec), 32'hFF);
    check("R9 reset febe", 32'(febe), 1);
    check("R9 reset tx crc", 32'(tx_crc), 0);
    check("R9 reset pulses", {30'd0, tx_crc_vld, rx_eval}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 6; s++) send_sf(1'b0, 1'b1, s == 3);
    send_sf(1'b1, 1'b1, 1'b0);
    send_sf(1'b0, 1'b0, 1'b0);
    send_sf(1'b1, 1'b0, 1'b0);
    send_sf(1'b0, 1'b1, 1'b0);
    send_sf(1'b0, 1'b1, 1'b1);
    for (int s = 0; s < 260; s++) send_sf(1'b1, s % 3 == 0, 1'b0);
    send_sf(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 counter at floor", 32'(bec), 0);
    check("R5 no pending tx", q_tx.size(), 0);
    check("R5 no pending rx", q_rx.size(), 0);

    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
    check("R9 soft bec", 32'(bec), 32'hFF);
    check("R9 soft febe", 32'(febe), 1);
    check("R9 soft tx crc", 32'(tx_crc), 0);
    k = 0; last_crc = '0; last_err = 1'b0; last_fb = 1'b1; bec_m = 8'hFF;

    send_sf(1'b0, 1'b1, 1'b0);
    send_sf(1'b1, 1'b1, 1'b0);
    send_sf(1'b1, 1'b0, 1'b0);
    send_sf(1'b0, 1'b1, 1'b1);
    send_sf(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R6 R7 counter after soft reset", 32'(bec), 32'hFD);
    check("R5 queues drained", q_tx.size() + q_rx.size(), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule